// File: doc/BRIEF.md
# Half-Bridge Dead-Time Gate Driver

This block sits behind an existing duty-cycle generator and turns its single PWM stream into a complementary pair of half-bridge gate signals. Output A is asserted while the PWM input is high, and output B is asserted while the input is low. A programmable dead time holds back every turn-on edge, so the upper and lower switches are never driven on together. Turn-off edges are applied at once.

The dead time is counted in instruction-cycle ticks. The block makes these ticks itself by dividing the system clock by four. The delay value is latched at each turn-on edge, so rewriting it never shortens a delay that is already running. Each output has its own active level. The polarity register accepts writes only while the block is stopped.

After the run enable goes high, both outputs stay inactive until the period-end strobe from the timebase makes a 0-to-1 transition. This guarantees that the first pulse driven to the bridge is a whole one. Dropping the run enable returns both outputs to their inactive levels in the same cycle.

Top module: `hb_deadtime_pwm`

## Requirements
- R1: After synchronous reset, `dt_rdata` reads 0, `pol_rdata` reads 0, and both gates are low, because both outputs are active-high and inactive.
- R2: `icyc_tick` is high for exactly one clock in every TICK_DIV clocks. Its first pulse comes in the TICK_DIV-th cycle after reset is released.
- R3: While `run_en` is high, both outputs stay inactive until `period_end` makes a 0-to-1 transition. A `period_end` that is already high when `run_en` rises does not arm the block.
- R4: Once armed and with a dead time of 0, output A is active in the same cycle that `pwm_in` is 1, and output B is active in the same cycle that `pwm_in` is 0.
- R5: With a dead time of N > 0, an output that becomes requested turns active right after the N-th tick edge following the clock edge on which the request rose. A tick on that edge itself does not count.
- R6: An output whose request drops goes inactive in the same cycle, with no delay.
- R7: A request that lasts fewer than N ticks never turns its output on. The next rising request restarts the count from N.
- R8: A write to `dt_wdata` with `dt_we` is readable on `dt_rdata` from the next cycle. It does not change a delay already in progress and takes effect at the next rising request.
- R9: `pol_rdata` bit 0 (output A) and bit 1 (output B) set to 1 make that output active-low. A polarity write with `pol_we` is ignored while `run_en` is high.
- R10: When `run_en` is low, both outputs are at their inactive levels in the same cycle. Raising `run_en` again requires a new `period_end` transition.
- R11: Outputs A and B are never active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable for the gate outputs |
| pwm_in | input | 1 | PWM stream from the duty-cycle generator |
| period_end | input | 1 | Period-end flag from the timebase |
| dt_we | input | 1 | Dead-time register write strobe |
| dt_wdata | input | DT_W | Dead time in ticks |
| pol_we | input | 1 | Polarity register write strobe |
| pol_wdata | input | 2 | Active-low selects, bit 0 for A and bit 1 for B |
| dt_rdata | output | DT_W | Dead-time register readback |
| pol_rdata | output | 2 | Polarity register readback |
| icyc_tick | output | 1 | Instruction-cycle tick (one clock in TICK_DIV) |
| gate_a | output | 1 | Gate drive, switch A |
| gate_b | output | 1 | Gate drive, switch B |

## Verification
The bench builds the block with its default parameters: DT_W = 8 and TICK_DIV = 4. With these values the largest dead time of 255 ticks spans about a thousand clocks, so the bench can measure the full range exactly, including the tick count at the boundary where the output turns on. Because the tick cadence is visible on a port, the bench can align turn-on edges against tick edges. It can also drive pulses just shorter than the delay and rewrite the dead time in the middle of a delay.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

    localparam int HBDT_DT_W_DEF = 8;
    localparam int HBDT_DIV_DEF  = 4;
    localparam int HBDT_NCH      = 2;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_WAIT = 2'd1,
        CH_ON   = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic b_low;
        logic a_low;
    } pol_t;

    function automatic logic drive_level(input logic active, input logic act_low);
        return active ^ act_low;
    endfunction

endpackage

// File: rtl/hbdt_tick_div.sv
module hbdt_tick_div #(
    parameter int DIV = hbdt_pkg::HBDT_DIV_DEF
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/hbdt_regs.sv
module hbdt_regs #(
    parameter int DT_W = hbdt_pkg::HBDT_DT_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run_en,
    input  logic            dt_we,
    input  logic [DT_W-1:0] dt_wdata,
    input  logic            pol_we,
    input  logic [1:0]      pol_wdata,
    output logic [DT_W-1:0] dt_q,
    output hbdt_pkg::pol_t  pol_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dt_q <= '0;
        end else if (dt_we) begin
            dt_q <= dt_wdata;
        end
    end

    // polarity is frozen while the outputs run
    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= '0;
        end else if (pol_we && !run_en) begin
            pol_q <= hbdt_pkg::pol_t'(pol_wdata);
        end
    end
endmodule

// File: rtl/hbdt_arm_gate.sv
module hbdt_arm_gate (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic period_end,
    output logic live
);
    logic pe_q;
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            pe_q <= 1'b0;
        end else begin
            pe_q <= period_end;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            armed <= 1'b0;
        end else if (period_end && !pe_q) begin
            armed <= 1'b1;
        end
    end

    assign live = armed && run_en;
endmodule

// File: rtl/hbdt_edge_delay.sv
module hbdt_edge_delay #(
    parameter int DT_W = hbdt_pkg::HBDT_DT_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            demand,
    input  logic [DT_W-1:0] dt_val,
    output logic            active
);
    import hbdt_pkg::*;

    ch_state_e       state;
    logic [DT_W-1:0] remain;
    logic            dt_zero;

    assign dt_zero = (dt_val == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CH_IDLE;
            remain <= '0;
        end else if (!demand) begin
            state  <= CH_IDLE;
            remain <= '0;
        end else begin
            unique case (state)
                CH_IDLE: begin
                    if (dt_zero) begin
                        state <= CH_ON;
                    end else begin
                        state  <= CH_WAIT;
                        remain <= dt_val;
                    end
                end
                CH_WAIT: begin
                    if (tick) begin
                        if (remain == DT_W'(1)) begin
                            state <= CH_ON;
                        end
                        remain <= remain - 1'b1;
                    end
                end
                CH_ON: begin
                    state <= CH_ON;
                end
                default: begin
                    state <= CH_IDLE;
                end
            endcase
        end
    end

    // turn-off is combinational; turn-on with zero delay also
    assign active = demand && ((state == CH_ON) || ((state == CH_IDLE) && dt_zero));
endmodule

// File: rtl/hb_deadtime_pwm.sv
module hb_deadtime_pwm #(
    parameter int DT_W     = hbdt_pkg::HBDT_DT_W_DEF,
    parameter int TICK_DIV = hbdt_pkg::HBDT_DIV_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run_en,
    input  logic            pwm_in,
    input  logic            period_end,
    input  logic            dt_we,
    input  logic [DT_W-1:0] dt_wdata,
    input  logic            pol_we,
    input  logic [1:0]      pol_wdata,
    output logic [DT_W-1:0] dt_rdata,
    output logic [1:0]      pol_rdata,
    output logic            icyc_tick,
    output logic            gate_a,
    output logic            gate_b
);
    import hbdt_pkg::*;

    localparam int NCH = HBDT_NCH;

    logic            tick;
    logic            live;
    logic [DT_W-1:0] dt_q;
    pol_t            pol_q;
    logic [NCH-1:0]  demand;
    logic [NCH-1:0]  act;

    hbdt_tick_div #(.DIV(TICK_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    hbdt_regs #(.DT_W(DT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .dt_we     (dt_we),
        .dt_wdata  (dt_wdata),
        .pol_we    (pol_we),
        .pol_wdata (pol_wdata),
        .dt_q      (dt_q),
        .pol_q     (pol_q)
    );

    hbdt_arm_gate u_arm (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .period_end (period_end),
        .live       (live)
    );

    assign demand[0] = live && pwm_in;
    assign demand[1] = live && !pwm_in;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            hbdt_edge_delay #(.DT_W(DT_W)) u_dly (
                .clk    (clk),
                .rst    (rst),
                .tick   (tick),
                .demand (demand[c]),
                .dt_val (dt_q),
                .active (act[c])
            );
        end
    endgenerate

    assign icyc_tick = tick;
    assign dt_rdata  = dt_q;
    assign pol_rdata = pol_q;
    assign gate_a    = drive_level(act[0], pol_q.a_low);
    assign gate_b    = drive_level(act[1], pol_q.b_low);
endmodule

// File: rtl/hbdt_checker.sv
module hbdt_checker #(
    parameter int DT_W = hbdt_pkg::HBDT_DT_W_DEF
) (
    input logic            clk,
    input logic            rst,
    input logic            run_en,
    input logic            pwm_in,
    input logic            icyc_tick,
    input logic            gate_a,
    input logic            gate_b,
    input logic [1:0]      pol_rdata,
    input logic [DT_W-1:0] dt_rdata
);
    logic on_a, on_b;
    assign on_a = gate_a != pol_rdata[0];
    assign on_b = gate_b != pol_rdata[1];

    p_dt_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dt_rdata == '0 && pol_rdata == 2'b00));

    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        icyc_tick |=> !icyc_tick);

    p_a_quick_off_r6: assert property (@(posedge clk) disable iff (rst)
        !pwm_in |-> !on_a);

    p_b_quick_off_r6: assert property (@(posedge clk) disable iff (rst)
        pwm_in |-> !on_b);

    p_pol_lock_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(run_en)) |-> $stable(pol_rdata));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> (!on_a && !on_b));

    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(on_a && on_b));
endmodule

bind hb_deadtime_pwm hbdt_checker #(.DT_W(DT_W)) u_hbdt_chk (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .pwm_in    (pwm_in),
    .icyc_tick (icyc_tick),
    .gate_a    (gate_a),
    .gate_b    (gate_b),
    .pol_rdata (pol_rdata),
    .dt_rdata  (dt_rdata)
);

// File: tb/test_hb_deadtime_pwm.sv
module test_hb_deadtime_pwm;
    localparam int CLK_PERIOD = 10;
    localparam int DT_W = 8;
    localparam int DIV  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b0, pwm_in = 1'b0, period_end = 1'b0;
    logic dt_we = 1'b0, pol_we = 1'b0;
    logic [DT_W-1:0] dt_wdata = '0;
    logic [1:0] pol_wdata = '0;
    logic [DT_W-1:0] dt_rdata;
    logic [1:0] pol_rdata;
    logic icyc_tick, gate_a, gate_b;

    int total = 0;
    int bad = 0;
    logic [1:0] exp_pol = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_deadtime_pwm #(.DT_W(DT_W), .TICK_DIV(DIV)) i_hb_deadtime_pwm (
        .clk(clk), .rst(rst), .run_en(run_en), .pwm_in(pwm_in),
        .period_end(period_end), .dt_we(dt_we), .dt_wdata(dt_wdata),
        .pol_we(pol_we), .pol_wdata(pol_wdata), .dt_rdata(dt_rdata),
        .pol_rdata(pol_rdata), .icyc_tick(icyc_tick),
        .gate_a(gate_a), .gate_b(gate_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected {b,a} active flags -> gate pins
    task automatic check_out(input string tag, input logic ea, input logic eb);
        check(tag, {30'd0, gate_b, gate_a}, {30'd0, eb ^ exp_pol[1], ea ^ exp_pol[0]});
    endtask

    task automatic ticks(input int n);
        int seen = 0;
        while (seen < n) begin
            if (icyc_tick) seen++;
            @(negedge clk);
        end
    endtask

    task automatic write_dt(input logic [DT_W-1:0] v);
        dt_wdata = v; dt_we = 1'b1;
        @(negedge clk);
        dt_we = 1'b0;
    endtask

    task automatic write_pol(input logic [1:0] v);
        pol_wdata = v; pol_we = 1'b1;
        @(negedge clk);
        pol_we = 1'b0;
    endtask

    task automatic arm();
        run_en = 1'b1;
        @(negedge clk);
        period_end = 1'b1;
        @(negedge clk);
        period_end = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 dt reset", 32'(dt_rdata), 32'd0);
        check("R1 pol reset", 32'(pol_rdata), 32'd0);
        check("R1 gates low", {30'd0, gate_b, gate_a}, 32'd0);
    endtask

    task automatic t_tick();
        int gap = 0;
        ticks(1);
        while (!icyc_tick) begin gap++; @(negedge clk); end
        check("R2 tick spacing", 32'(gap + 1), 32'(DIV));
    endtask

    task automatic t_arm();
        write_dt('0);
        pwm_in = 1'b1;
        period_end = 1'b1;
        repeat (3) @(negedge clk);
        run_en = 1'b1;
        repeat (5) @(negedge clk);
        check_out("R3 held-high period_end does not arm", 1'b0, 1'b0);
        period_end = 1'b0;
        repeat (2) @(negedge clk);
        check_out("R3 no arm without transition", 1'b0, 1'b0);
        period_end = 1'b1;
        #1;
        check_out("R3 off until edge registered", 1'b0, 1'b0);
        @(negedge clk);
        period_end = 1'b0;
        #1;
        check_out("R4 A follows pwm after arming", 1'b1, 1'b0);
    endtask

    task automatic t_follow();
        pwm_in = 1'b0; #1;
        check_out("R4 B is complement, zero delay", 1'b0, 1'b1);
        @(negedge clk);
        pwm_in = 1'b1; #1;
        check_out("R4 A active same cycle", 1'b1, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_delay(input int n);
        write_dt(DT_W'(n));
        pwm_in = 1'b0; #1;
        check_out("R6 A off at once", 1'b0, 1'b0);
        @(negedge clk);
        ticks(n - 1);
        check_out("R5 B still off one tick early", 1'b0, 1'b0);
        ticks(1);
        check_out("R5 B on after N ticks", 1'b0, 1'b1);
        pwm_in = 1'b1; #1;
        check_out("R6 B off at once", 1'b0, 1'b0);
        @(negedge clk);
        ticks(n - 1);
        check_out("R5 A still off one tick early", 1'b0, 1'b0);
        ticks(1);
        check_out("R5 A on after N ticks", 1'b1, 1'b0);
    endtask

    task automatic t_short();
        write_dt(DT_W'(5));
        pwm_in = 1'b0;
        @(negedge clk);
        ticks(3);
        pwm_in = 1'b1;
        @(negedge clk);
        check_out("R7 short gap suppresses B", 1'b0, 1'b0);
        ticks(4);
        check_out("R7 A restarted, not yet on", 1'b0, 1'b0);
        ticks(1);
        check_out("R7 A on after full restart", 1'b1, 1'b0);
    endtask

    task automatic t_dt_change();
        write_dt(DT_W'(6));
        pwm_in = 1'b0;
        @(negedge clk);
        ticks(1);
        write_dt(DT_W'(1));
        #1;
        check("R8 dt readback", 32'(dt_rdata), 32'd1);
        ticks(4);
        check_out("R8 running delay not shortened", 1'b0, 1'b0);
        ticks(1);
        check_out("R8 old delay completes", 1'b0, 1'b1);
        pwm_in = 1'b1;
        @(negedge clk);
        ticks(1);
        check_out("R8 new delay used on next edge", 1'b1, 1'b0);
    endtask

    task automatic t_disable();
        run_en = 1'b0; #1;
        check_out("R10 disable forces inactive", 1'b0, 1'b0);
        @(negedge clk);
        run_en = 1'b1;
        repeat (6) @(negedge clk);
        check_out("R10 re-enable needs period_end", 1'b0, 1'b0);
    endtask

    task automatic t_polarity();
        run_en = 1'b0;
        @(negedge clk);
        write_pol(2'b11);
        exp_pol = 2'b11;
        #1;
        check("R9 pol readback", 32'(pol_rdata), 32'd3);
        check("R9 inactive-low pins high", {30'd0, gate_b, gate_a}, 32'd3);
        run_en = 1'b1;
        @(negedge clk);
        write_pol(2'b00);
        #1;
        check("R9 write ignored while running", 32'(pol_rdata), 32'd3);
        write_dt('0);
        pwm_in = 1'b1;
        arm();
        #1;
        check("R9 active-low A drives 0", {30'd0, gate_b, gate_a}, 32'd2);
        run_en = 1'b0; #1;
        check("R10 disable with active-low", {30'd0, gate_b, gate_a}, 32'd3);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_tick();
        t_arm();
        t_follow();
        t_delay(3);
        t_delay(255);
        t_short();
        t_dt_change();
        t_disable();
        t_polarity();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule